// File: doc/BRIEF.md
# Multi-pair ADC conversion sequencer

This controller sequences the conversions of a converter that holds several channel pairs, each sampled together as one unit. Each pair has its own conversion-start line. A rising edge seen while the sequencer is idle latches every pair whose line rose in that cycle. The sequencer then converts those pairs one after another, lowest pair index first. Each conversion takes a fixed number of conversion-clock cycles, and the analog work itself is not modelled. An optional auto-sleep mode adds a settling delay of six cycles before the first conversion.

A single status pin reports progress. In busy mode it is high while conversions run. It dips for one cycle between pairs and stays low after the last pair. In interrupt mode it rises when the whole sequence completes and falls on the next read strobe. A configuration bit inverts the pin in either mode. A readout pointer names the channel that the next read returns. A read strobe advances it, and an accepted start edge on pair A sends it back to channel A0.

The configuration word is written with a load strobe and is visible on an output. Reset stops any conversion in progress, clears the pointer and the interrupt flag, and loads the word with 0x000003FF. In that reset value the interrupt, polarity and auto-sleep bits are all zero.

Top module: `conv_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the design shows the following. `status_out` is 0, `rd_ptr` is 0 and `cfg_q` is 0x000003FF. Any conversion in progress is abandoned, so the status does not return high after reset until a new start edge arrives.
- R2: A rising edge on any `conv_start` bit while the sequencer is idle starts a sequence. In busy mode with normal polarity, `status_out` is 1 in the first cycle after the clock edge that sampled the rising edge.
- R3: The pairs latched at the start are converted in ascending index order. Each conversion lasts CONV_CYC cycles, and during it `conv_pair` shows the index of that pair (0 = A, 1 = B, 2 = C, 3 = D).
- R4: In busy mode, `status_out` is low for exactly one cycle between the end of one pair and the start of the next latched pair.
- R5: In busy mode, `status_out` goes low in the cycle after the last latched pair ends and stays low while the sequencer is idle.
- R6: Configuration bit 20 set to 1 selects interrupt mode. In this mode `status_out` is low during a sequence and high from the cycle after the last pair ends. It stays high until a cycle with `rd_strobe` high, and is low in the cycle after that strobe.
- R7: Configuration bit 21 set to 1 inverts `status_out` in every cycle, compared with the value R2 to R6 give.
- R8: Configuration bit 22 set to 1 selects auto-sleep. In this mode SLEEP_CYC (6) cycles pass after the start edge before the first conversion begins, and the status reads busy during those cycles.
- R9: A start edge that is accepted and includes pair A (bit 0) sets `rd_ptr` to 0 in the next cycle. This takes priority over a read in the same cycle.
- R10: Each `rd_strobe` cycle advances `rd_ptr` by one, and the pointer wraps from 2*NUM_PAIRS-1 (7) to 0.
- R11: Start edges that arrive while a sequence runs are ignored. They change neither the set of pairs converted nor `rd_ptr`.
- R12: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration word, which appears on `cfg_q` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | NUM_PAIRS | Conversion-start line per pair; bit 0 is pair A |
| rd_strobe | input | 1 | One read access per high cycle |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | CFG_W | Configuration word to load |
| cfg_q | output | CFG_W | Current configuration word |
| status_out | output | 1 | Busy or interrupt status, polarity selectable |
| rd_ptr | output | $clog2(2*NUM_PAIRS) | Channel returned by the next read |
| conv_pair | output | $clog2(NUM_PAIRS) | Pair being converted |

## Verification
The status pin changes in the first cycle after the clock edge that sampled a start edge. After that, every transition can be worked out from the start cycle. Each pair adds CONV_CYC busy cycles plus one dip cycle when another pair follows, and auto-sleep adds SLEEP_CYC cycles at the front. The interrupt flag rises in the cycle after the last conversion ends. The driver task computes this timeline from the cycle in which it raises the start lines and queues one expected status value, together with a pair index where one is defined, for each cycle. A monitor compares each queued value at the falling edge of that cycle. Pointer, configuration and interrupt-clear results are due one cycle after the strobe that causes them, and they are sampled at the next falling edge.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  localparam int MAX_PAIRS = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SLEEP = 2'd1,
    SEQ_CONV  = 2'd2,
    SEQ_GAP   = 2'd3
  } seq_state_e;

  // Index of the lowest set bit; 0 when the mask is empty.
  function automatic int unsigned lowest_idx(input logic [MAX_PAIRS-1:0] m);
    int unsigned idx;
    idx = 0;
    for (int i = MAX_PAIRS - 1; i >= 0; i--) begin
      if (m[i]) idx = i;
    end
    return idx;
  endfunction

  // Next readout channel, wrapping after the last channel.
  function automatic int unsigned ptr_advance(input int unsigned p, input int unsigned nch);
    return (p >= nch - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/conv_seq_edge.sv
module conv_seq_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = lvl[g] & ~prev_q[g];
  end
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CONV_CYC  = 5,
  parameter int SLEEP_CYC = 6,
  localparam int PW = $clog2(NUM_PAIRS),
  localparam int MAXC = (CONV_CYC > SLEEP_CYC) ? CONV_CYC : SLEEP_CYC,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PAIRS-1:0] rise,
  input  logic                 autosleep,
  output logic                 accept,
  output logic                 busy_raw,
  output logic                 pair_done,
  output logic                 last_done,
  output logic [PW-1:0]        cur_pair
);
  seq_state_e           state_q;
  logic [NUM_PAIRS-1:0] pending_q;
  logic [NUM_PAIRS-1:0] rest;
  logic [CW-1:0]        cnt_q;

  assign accept    = (state_q == SEQ_IDLE) && (|rise);
  assign busy_raw  = (state_q == SEQ_SLEEP) || (state_q == SEQ_CONV);
  assign rest      = pending_q & ~(NUM_PAIRS'(1) << cur_pair);
  assign pair_done = (state_q == SEQ_CONV) && (cnt_q == CW'(CONV_CYC - 1));
  assign last_done = pair_done && (rest == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      pending_q <= '0;
      cnt_q     <= '0;
      cur_pair  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            pending_q <= rise;
            cur_pair  <= PW'(lowest_idx(MAX_PAIRS'(rise)));
            cnt_q     <= '0;
            state_q   <= autosleep ? SEQ_SLEEP : SEQ_CONV;
          end
        end
        SEQ_SLEEP: begin
          if (cnt_q == CW'(SLEEP_CYC - 1)) begin
            cnt_q   <= '0;
            state_q <= SEQ_CONV;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_CONV: begin
          if (pair_done) begin
            cnt_q     <= '0;
            pending_q <= rest;
            if (last_done) begin
              state_q <= SEQ_IDLE;
            end else begin
              cur_pair <= PW'(lowest_idx(MAX_PAIRS'(rest)));
              state_q  <= SEQ_GAP;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_GAP: state_q <= SEQ_CONV;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_status.sv
module conv_seq_status
  import conv_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int PTW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           busy_raw,
  input  logic           last_done,
  input  logic           rd_strobe,
  input  logic           ptr_clear,
  input  logic           int_mode,
  input  logic           polarity,
  output logic           int_flag,
  output logic           status_out,
  output logic [PTW-1:0] rd_ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      int_flag <= 1'b0;
      rd_ptr   <= '0;
    end else begin
      if (last_done)      int_flag <= 1'b1;
      else if (rd_strobe) int_flag <= 1'b0;

      if (ptr_clear)      rd_ptr <= '0;
      else if (rd_strobe) rd_ptr <= PTW'(ptr_advance(int'(rd_ptr), NCH));
    end
  end

  assign status_out = (int_mode ? int_flag : busy_raw) ^ polarity;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int          NUM_PAIRS = 4,
  parameter int          CONV_CYC  = 5,
  parameter int          SLEEP_CYC = 6,
  parameter int          CFG_W     = 32,
  parameter logic [31:0] CFG_RESET = 32'h0000_03FF,
  parameter int          INT_BIT   = 20,
  parameter int          POL_BIT   = 21,
  parameter int          SLEEP_BIT = 22
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PAIRS-1:0]            conv_start,
  input  logic                            rd_strobe,
  input  logic                            cfg_we,
  input  logic [CFG_W-1:0]                cfg_wdata,
  output logic [CFG_W-1:0]                cfg_q,
  output logic                            status_out,
  output logic [$clog2(2*NUM_PAIRS)-1:0]  rd_ptr,
  output logic [$clog2(NUM_PAIRS)-1:0]    conv_pair
);
  localparam int NCH = 2 * NUM_PAIRS;

  logic [NUM_PAIRS-1:0] rise;
  logic accept, accept_a, busy_raw, pair_done, last_done, int_flag;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_W'(CFG_RESET);
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  conv_seq_edge #(.N(NUM_PAIRS)) u_edge (
    .clk(clk), .rst(rst), .lvl(conv_start), .rise(rise)
  );

  conv_seq_fsm #(
    .NUM_PAIRS(NUM_PAIRS), .CONV_CYC(CONV_CYC), .SLEEP_CYC(SLEEP_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .rise(rise), .autosleep(cfg_q[SLEEP_BIT]),
    .accept(accept), .busy_raw(busy_raw), .pair_done(pair_done),
    .last_done(last_done), .cur_pair(conv_pair)
  );

  assign accept_a = accept && rise[0];

  conv_seq_status #(.NCH(NCH)) u_status (
    .clk(clk), .rst(rst), .busy_raw(busy_raw), .last_done(last_done),
    .rd_strobe(rd_strobe), .ptr_clear(accept_a),
    .int_mode(cfg_q[INT_BIT]), .polarity(cfg_q[POL_BIT]),
    .int_flag(int_flag), .status_out(status_out), .rd_ptr(rd_ptr)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int          NUM_PAIRS = 4,
  parameter int          CFG_W     = 32,
  parameter logic [31:0] CFG_RESET = 32'h0000_03FF,
  localparam int NCH = 2 * NUM_PAIRS
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_PAIRS-1:0]           rise,
  input logic                           rd_strobe,
  input logic                           accept,
  input logic                           accept_a,
  input logic                           busy_raw,
  input logic                           pair_done,
  input logic                           last_done,
  input logic                           int_flag,
  input logic [CFG_W-1:0]               cfg_q,
  input logic [$clog2(NCH)-1:0]         rd_ptr,
  input logic [$clog2(NUM_PAIRS)-1:0]   conv_pair
);
  logic rst_seen;
  always @(posedge clk) rst_seen <= rst;

  // R1: state right after a reset edge
  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      assert_reset_state_R1: assert (cfg_q == CFG_W'(CFG_RESET) && rd_ptr == '0
                                     && !busy_raw && !int_flag);
    end
  end

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_raw);

  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    (pair_done && !last_done) |=> (conv_pair > $past(conv_pair)));

  assert_gap_dip_R4: assert property (@(posedge clk) disable iff (rst)
    (pair_done && !last_done) |=> (!busy_raw ##1 busy_raw));

  assert_last_low_R5: assert property (@(posedge clk) disable iff (rst)
    last_done |=> !busy_raw);

  assert_int_set_R6: assert property (@(posedge clk) disable iff (rst)
    last_done |=> int_flag);

  assert_int_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !last_done) |=> !int_flag);

  assert_ptr_reset_R9: assert property (@(posedge clk) disable iff (rst)
    accept_a |=> (rd_ptr == '0));

  assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !accept_a && rd_ptr == ($clog2(NCH))'(NCH - 1)) |=> (rd_ptr == '0));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_raw && rise[0] && !rd_strobe) |=> $stable(rd_ptr));
endmodule

bind conv_sequencer conv_sequencer_chk #(
  .NUM_PAIRS(NUM_PAIRS), .CFG_W(CFG_W), .CFG_RESET(CFG_RESET)
) u_chk (
  .clk(clk), .rst(rst), .rise(rise), .rd_strobe(rd_strobe), .accept(accept),
  .accept_a(accept_a), .busy_raw(busy_raw), .pair_done(pair_done),
  .last_done(last_done), .int_flag(int_flag), .cfg_q(cfg_q), .rd_ptr(rd_ptr),
  .conv_pair(conv_pair)
);

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  localparam int CONV = 5;
  localparam int SLP  = 6;
  localparam logic [31:0] BASE = 32'h0000_03FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  conv_start = '0;
  logic        rd_strobe = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_q;
  logic        status_out;
  logic [2:0]  rd_ptr;
  logic [1:0]  conv_pair;

  conv_sequencer uut (
    .clk(clk), .rst(rst), .conv_start(conv_start), .rd_strobe(rd_strobe),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .status_out(status_out), .rd_ptr(rd_ptr), .conv_pair(conv_pair)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_ptr  = 0;

  typedef struct {
    int    at;
    logic  st;
    int    pair;
    bit    chk_pair;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int at, input logic st, input int pair,
                      input bit cp, input string tag);
    exp_t e;
    e.at = at; e.st = st; e.pair = pair; e.chk_pair = cp; e.tag = tag;
    sb.push_back(e);
  endtask

  // Scoreboard monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(status_out === e.st, e.tag, "status_out", status_out, e.st);
      if (e.chk_pair)
        check(conv_pair === 2'(e.pair), "R3", "conv_pair", conv_pair, e.pair);
    end
  end

  // Driver: raises start lines at a falling edge and queues the timeline.
  task automatic launch(input logic [3:0] mask, input bit slp, input bit pol,
                        input bit imode);
    int t, n, seen;
    logic busy_v, idle_v;
    busy_v = imode ? pol : ~pol;
    idle_v = pol;
    t = cyc + 1;
    conv_start = conv_start | mask;
    n = $countones(mask);
    seen = 0;
    if (slp) begin
      for (int k = 0; k < SLP; k++) push(t + k, busy_v, 0, 1'b0, "R8");
      t = t + SLP;
    end
    for (int p = 0; p < 4; p++) begin
      if (mask[p]) begin
        seen++;
        for (int k = 0; k < CONV; k++)
          push(t + k, busy_v, p, !imode, (k == 0 && seen == 1) ? "R2" : "R3");
        t = t + CONV;
        if (seen < n) begin
          push(t, idle_v, 0, 1'b0, "R4");
          t = t + 1;
        end
      end
    end
    if (imode) begin
      push(t, ~pol, 0, 1'b0, "R6");
      push(t + 1, ~pol, 0, 1'b0, "R6");
    end else begin
      push(t, idle_v, 0, 1'b0, pol ? "R7" : "R5");
      push(t + 2, idle_v, 0, 1'b0, pol ? "R7" : "R5");
    end
    if (mask[0]) exp_ptr = 0;
    @(negedge clk);
    conv_start = conv_start & ~mask;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_wdata = d;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_q === d, "R12", "cfg_q", cfg_q, d);
  endtask

  task automatic do_read(input string req);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    exp_ptr = (exp_ptr == 7) ? 0 : exp_ptr + 1;
    check(rd_ptr === 3'(exp_ptr), req, "rd_ptr", rd_ptr, exp_ptr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status_out === 1'b0, "R1", "status in reset", status_out, 0);
    check(rd_ptr === 3'd0, "R1", "rd_ptr in reset", rd_ptr, 0);
    check(cfg_q === BASE, "R1", "cfg_q in reset", cfg_q, BASE);
    rst = 1'b0;
    @(negedge clk);
    check(status_out === 1'b0, "R1", "status after reset", status_out, 0);

    // Single pair, all pairs, sparse pairs (busy mode, normal polarity)
    launch(4'b0001, 1'b0, 1'b0, 1'b0); drain();
    check(rd_ptr === 3'd0, "R9", "rd_ptr after A start", rd_ptr, 0);
    launch(4'b1111, 1'b0, 1'b0, 1'b0); drain();
    launch(4'b1010, 1'b0, 1'b0, 1'b0); drain();

    // R11: pair B edge during a running sequence is not converted
    launch(4'b0001, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    conv_start[1] = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    check(status_out === 1'b0, "R11", "status after ignored edge", status_out, 0);
    conv_start[1] = 1'b0;
    @(negedge clk);

    // R8 auto-sleep, then R7 inverted polarity
    cfg_write(BASE | (32'd1 << 22));
    launch(4'b0101, 1'b1, 1'b0, 1'b0); drain();
    cfg_write(BASE | (32'd1 << 21));
    check(status_out === 1'b1, "R7", "idle inverted", status_out, 1);
    launch(4'b0011, 1'b0, 1'b1, 1'b0); drain();

    // R6 interrupt mode
    cfg_write(BASE | (32'd1 << 20));
    do_read("R10");
    check(status_out === 1'b0, "R6", "flag cleared by read", status_out, 0);
    launch(4'b1111, 1'b0, 1'b0, 1'b1); drain();
    repeat (4) @(negedge clk);
    check(status_out === 1'b1, "R6", "flag holds until read", status_out, 1);
    do_read("R6");
    check(status_out === 1'b0, "R6", "flag low after read", status_out, 0);

    // R10 pointer walk and wrap
    cfg_write(BASE);
    launch(4'b0001, 1'b0, 1'b0, 1'b0); drain();
    check(rd_ptr === 3'd0, "R9", "rd_ptr after A start", rd_ptr, 0);
    for (int i = 0; i < 11; i++) do_read("R10");

    // R9/R11: start without A keeps pointer; A edge while busy ignored
    launch(4'b0100, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(rd_ptr === 3'(exp_ptr), "R9", "rd_ptr kept without A", rd_ptr, exp_ptr);
    conv_start[0] = 1'b1;
    @(negedge clk);
    conv_start[0] = 1'b0;
    drain();
    check(rd_ptr === 3'(exp_ptr), "R11", "rd_ptr after busy A edge", rd_ptr, exp_ptr);
    launch(4'b0001, 1'b0, 1'b0, 1'b0); drain();
    check(rd_ptr === 3'd0, "R9", "rd_ptr after idle A edge", rd_ptr, 0);

    // R1 reset aborts a running sequence
    do_read("R10");
    cfg_write(BASE | (32'd1 << 22));
    conv_start = 4'b1110;
    repeat (3) @(negedge clk);
    check(status_out === 1'b1, "R2", "busy before abort", status_out, 1);
    rst = 1'b1;
    conv_start = 4'b0000;
    repeat (2) @(negedge clk);
    check(cfg_q === BASE, "R1", "cfg_q after reset", cfg_q, BASE);
    check(rd_ptr === 3'd0, "R1", "rd_ptr after reset", rd_ptr, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(status_out === 1'b0, "R1", "aborted stays low", status_out, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule